// File: doc/BRIEF.md
# Strided Multi-Dimensional Field Extractor

This block is a purely combinational read port. It takes one wide packed vector and returns a single fixed-width field from it. The field's position is set by a group of runtime indices, one per dimension. Each dimension has a compile-time stride, which is the bit distance between neighbouring index values, and a compile-time top index. A fixed base offset shifts the whole grid of fields. The block works like an indexed read of a packed multi-dimensional array whose layout is known when the design is built.

The per-dimension indices are joined into one linear select. That select drives a multiplexer over every candidate field, and each candidate slice is placed by a constant computed at elaboration. Each dimension's index range must be a power of two. Because of this, joining the index fields gives exactly the linear enumeration number and every select value maps to a real candidate. When the configuration has only one candidate, the block drives the base field directly and ignores the index bus.

Elaboration stops on three kinds of bad parameter set: strides that grow from one dimension to the next, index ranges that are not powers of two, and a grid whose last field runs past the top of the vector.

Top module: `strided_field_pick`

## Requirements
- R1: For every index combination, `fieldOut` equals `vecIn[BASE_OFF + sum(idx_d * STEP[d]) +: FIELD_W]`. The number of distinct selectable fields is the product of (MAXI[d] + 1) over all dimensions.
- R2: The index bus packs dimension 0, which has the largest stride, in its most significant bits. Each dimension d takes max(1, log2(MAXI[d]+1)) bits. With the default parameters, bits [2:1] carry dimension 0 (stride 16, indices 0..3) and bit [0] carries dimension 1 (stride 5, indices 0..1).
- R3: Bits of `vecIn` outside the selected field have no effect on `fieldOut`.
- R4: The output follows any change of `vecIn` or `idxIn` with no clock edge in between.
- R5: Candidates are enumerated with the smallest-stride dimension varying fastest. The linear select value k, formed by joining the index fields, picks the k-th candidate, counting from zero.
- R6: All-zero indices select the field that starts at BASE_OFF.
- R7: All indices at their maximum select the highest field, which starts at BASE_OFF + sum(MAXI[d] * STEP[d]).
- R8: In a configuration with a single candidate, `fieldOut` equals `vecIn[BASE_OFF +: FIELD_W]` whatever value `idxIn` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vecIn | input | VEC_W | Packed source vector |
| idxIn | input | IDX_W (derived) | Joined per-dimension indices, dimension 0 in the top bits |
| fieldOut | output | FIELD_W | Selected field |

## Verification
The hardest case to reach is a wrong candidate that happens to carry the same bits as the right one. With structured data, a shifted offset or swapped dimension order can produce matching values and go unseen. The bench therefore fills the vector with varied random words. It sweeps every index combination and every linear select value, and it compares each result against a slice computed from the stride formula. It also flips every bit outside the chosen field to show those bits have no effect.

// File: rtl/strided_field_pick_pkg.sv
package strided_field_pick_pkg;

  localparam int unsigned MAX_DIMS = 8;
  localparam int unsigned SEL_MAX_W = 16;

  typedef int unsigned dimList_t [MAX_DIMS];

  typedef struct packed {
    logic                 passMode;
    logic [SEL_MAX_W-1:0] linSel;
  } pickStrobe_t;

  function automatic int unsigned idxWidth(int unsigned m);
    return (m == 0) ? 1 : $clog2(m + 1);
  endfunction

  function automatic int unsigned selWidth(int unsigned m);
    return $clog2(m + 1);
  endfunction

  function automatic int unsigned idxBusW(int unsigned n, dimList_t mx);
    int unsigned w = 0;
    for (int unsigned d = 0; d < n; d++) w += idxWidth(mx[d]);
    return w;
  endfunction

  function automatic int unsigned idxPos(int unsigned n, dimList_t mx, int unsigned d);
    int unsigned p = 0;
    for (int unsigned e = d + 1; e < n; e++) p += idxWidth(mx[e]);
    return p;
  endfunction

  function automatic int unsigned selPos(int unsigned n, dimList_t mx, int unsigned d);
    int unsigned p = 0;
    for (int unsigned e = d + 1; e < n; e++) p += selWidth(mx[e]);
    return p;
  endfunction

  function automatic int unsigned elemCount(int unsigned n, dimList_t mx);
    int unsigned c = 1;
    for (int unsigned d = 0; d < n; d++) c *= (mx[d] + 1);
    return c;
  endfunction

  function automatic int unsigned candOff(int unsigned n, int unsigned base,
                                          dimList_t st, dimList_t mx, int unsigned k);
    int unsigned off = base;
    int unsigned rem = k;
    for (int d = int'(n) - 1; d >= 0; d--) begin
      off += (rem % (mx[d] + 1)) * st[d];
      rem = rem / (mx[d] + 1);
    end
    return off;
  endfunction

  function automatic int unsigned topOff(int unsigned n, int unsigned base,
                                         dimList_t st, dimList_t mx);
    int unsigned off = base;
    for (int unsigned d = 0; d < n; d++) off += mx[d] * st[d];
    return off;
  endfunction

  function automatic bit stepsOrdered(int unsigned n, dimList_t st);
    for (int unsigned d = 1; d < n; d++) if (st[d] > st[d-1]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit rangesPow2(int unsigned n, dimList_t mx);
    for (int unsigned d = 0; d < n; d++) if (((mx[d] + 1) & mx[d]) != 0) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/strided_field_pick_ctrl.sv
module strided_field_pick_ctrl
  import strided_field_pick_pkg::*;
#(
  parameter int unsigned NDIM = 2,
  parameter dimList_t    MAXI = '{3, 1, 0, 0, 0, 0, 0, 0},
  localparam int unsigned IDX_W = idxBusW(NDIM, MAXI),
  localparam int unsigned COUNT = elemCount(NDIM, MAXI)
) (
  input  logic [IDX_W-1:0] idxIn,
  output pickStrobe_t      strobe
);

  logic [SEL_MAX_W-1:0] joined;
  logic                 unusedIdx;

  always_comb begin
    joined = '0;
    for (int unsigned d = 0; d < NDIM; d++) begin
      joined = joined | SEL_MAX_W'((32'(idxIn >> idxPos(NDIM, MAXI, d))
                                    & ((32'd1 << selWidth(MAXI[d])) - 32'd1))
                                   << selPos(NDIM, MAXI, d));
    end
  end

  assign unusedIdx = ^idxIn;

  always_comb begin
    strobe.passMode = (COUNT == 1);
    strobe.linSel   = joined;
  end

endmodule

// File: rtl/strided_field_pick_dp.sv
module strided_field_pick_dp
  import strided_field_pick_pkg::*;
#(
  parameter int unsigned VEC_W    = 64,
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned BASE_OFF = 2,
  parameter int unsigned NDIM     = 2,
  parameter dimList_t    STEP     = '{16, 5, 0, 0, 0, 0, 0, 0},
  parameter dimList_t    MAXI     = '{3, 1, 0, 0, 0, 0, 0, 0},
  localparam int unsigned COUNT   = elemCount(NDIM, MAXI),
  localparam int unsigned SEL_W   = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic [VEC_W-1:0]   vecIn,
  input  pickStrobe_t        strobe,
  output logic [FIELD_W-1:0] fieldOut
);

  logic [FIELD_W-1:0] cand [COUNT];
  logic [SEL_W-1:0]   pick;
  logic               unusedBits;

  for (genvar k = 0; k < COUNT; k++) begin : gCand
    localparam int unsigned OFF_K = candOff(NDIM, BASE_OFF, STEP, MAXI, k);
    assign cand[k] = vecIn[OFF_K +: FIELD_W];
  end

  assign pick       = strobe.linSel[SEL_W-1:0];
  assign unusedBits = ^vecIn ^ (^strobe.linSel);

  always_comb begin
    if (strobe.passMode) fieldOut = vecIn[BASE_OFF +: FIELD_W];
    else                 fieldOut = cand[pick];
  end

endmodule

// File: rtl/strided_field_pick.sv
module strided_field_pick
  import strided_field_pick_pkg::*;
#(
  parameter int unsigned VEC_W    = 64,
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned BASE_OFF = 2,
  parameter int unsigned NDIM     = 2,
  parameter dimList_t    STEP     = '{16, 5, 0, 0, 0, 0, 0, 0},
  parameter dimList_t    MAXI     = '{3, 1, 0, 0, 0, 0, 0, 0},
  localparam int unsigned IDX_W   = idxBusW(NDIM, MAXI)
) (
  input  logic [VEC_W-1:0]   vecIn,
  input  logic [IDX_W-1:0]   idxIn,
  output logic [FIELD_W-1:0] fieldOut
);

  if (!stepsOrdered(NDIM, STEP)) begin : gBadOrder
    $error("dimension strides must not increase");
  end
  if (!rangesPow2(NDIM, MAXI)) begin : gBadRange
    $error("each index range must be a power of two");
  end
  if (topOff(NDIM, BASE_OFF, STEP, MAXI) + FIELD_W > VEC_W) begin : gBadFit
    $error("highest field exceeds the vector width");
  end
  if (NDIM == 0 || NDIM > MAX_DIMS) begin : gBadDims
    $error("dimension count out of range");
  end

  pickStrobe_t ctrlStrobe;

  strided_field_pick_ctrl #(
    .NDIM(NDIM), .MAXI(MAXI)
  ) uCtrl (
    .idxIn (idxIn),
    .strobe(ctrlStrobe)
  );

  strided_field_pick_dp #(
    .VEC_W(VEC_W), .FIELD_W(FIELD_W), .BASE_OFF(BASE_OFF),
    .NDIM(NDIM), .STEP(STEP), .MAXI(MAXI)
  ) uDp (
    .vecIn   (vecIn),
    .strobe  (ctrlStrobe),
    .fieldOut(fieldOut)
  );

endmodule

// File: rtl/strided_field_pick_chk.sv
module strided_field_pick_chk
  import strided_field_pick_pkg::*;
#(
  parameter int unsigned VEC_W    = 64,
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned BASE_OFF = 2,
  parameter int unsigned NDIM     = 2,
  parameter dimList_t    STEP     = '{16, 5, 0, 0, 0, 0, 0, 0},
  parameter dimList_t    MAXI     = '{3, 1, 0, 0, 0, 0, 0, 0},
  localparam int unsigned IDX_W   = idxBusW(NDIM, MAXI),
  localparam int unsigned COUNT   = elemCount(NDIM, MAXI)
) (
  input logic [VEC_W-1:0]   vecIn,
  input logic [IDX_W-1:0]   idxIn,
  input logic [FIELD_W-1:0] fieldOut,
  input pickStrobe_t        strobe
);

  int unsigned refOff;
  int unsigned refLin;
  logic        allMax;

  always_comb begin
    refOff = BASE_OFF;
    refLin = 0;
    allMax = 1'b1;
    for (int unsigned d = 0; d < NDIM; d++) begin
      int unsigned v;
      v = 32'(idxIn >> idxPos(NDIM, MAXI, d)) & ((32'd1 << idxWidth(MAXI[d])) - 32'd1);
      refOff = refOff + v * STEP[d];
      refLin = refLin * (MAXI[d] + 1) + v;
      if (v != MAXI[d]) allMax = 1'b0;
    end
  end

  always_comb begin
    if (COUNT > 1) begin
      assert_field_match_R1: assert (fieldOut == vecIn[refOff +: FIELD_W]);
      assert_sel_order_R5: assert (32'(strobe.linSel) == refLin);
      if (idxIn == '0)
        assert_zero_index_R6: assert (fieldOut == vecIn[BASE_OFF +: FIELD_W]);
      if (allMax)
        assert_top_index_R7: assert
          (fieldOut == vecIn[topOff(NDIM, BASE_OFF, STEP, MAXI) +: FIELD_W]);
    end else begin
      assert_pass_through_R8: assert (fieldOut == vecIn[BASE_OFF +: FIELD_W]);
    end
  end

endmodule

bind strided_field_pick strided_field_pick_chk #(
  .VEC_W(VEC_W), .FIELD_W(FIELD_W), .BASE_OFF(BASE_OFF),
  .NDIM(NDIM), .STEP(STEP), .MAXI(MAXI)
) uChk (
  .vecIn   (vecIn),
  .idxIn   (idxIn),
  .fieldOut(fieldOut),
  .strobe  (ctrlStrobe)
);

// File: tb/strided_field_pick_test.sv
module strided_field_pick_test;
  import strided_field_pick_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  logic [63:0] vecIn;
  logic [2:0]  idxIn;
  logic [3:0]  fieldOut;

  logic [7:0]  sVec;
  logic [0:0]  sIdx;
  logic [2:0]  sOut;

  strided_field_pick uut (.vecIn(vecIn), .idxIn(idxIn), .fieldOut(fieldOut));

  strided_field_pick #(
    .VEC_W(8), .FIELD_W(3), .BASE_OFF(2), .NDIM(1),
    .STEP('{1, 0, 0, 0, 0, 0, 0, 0}), .MAXI('{0, 0, 0, 0, 0, 0, 0, 0})
  ) uutSingle (.vecIn(sVec), .idxIn(sIdx), .fieldOut(sOut));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [3:0] refField(logic [63:0] v, int i0, int i1);
    return v[2 + 16 * i0 + 5 * i1 +: 4];
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic randVec();
    vecIn = {$urandom, $urandom};
  endtask

  task automatic testReset();
    vecIn = '0; idxIn = '0; sVec = '0; sIdx = '0;
    settle(); #1;
    check("R6 zero state", 32'(fieldOut), 32'h0);
    check("R8 zero state", 32'(sOut), 32'h0);
  endtask

  task automatic testSweep();
    for (int pass = 0; pass < 6; pass++) begin
      randVec();
      for (int i0 = 0; i0 < 4; i0++) begin
        for (int i1 = 0; i1 < 2; i1++) begin
          idxIn = 3'((i0 << 1) | i1);
          settle(); #1;
          check("R1/R2 sweep", 32'(fieldOut), 32'(refField(vecIn, i0, i1)));
        end
      end
    end
  endtask

  task automatic testLinear();
    randVec();
    for (int k = 0; k < 8; k++) begin
      idxIn = 3'(k);
      settle(); #1;
      check("R5 linear order", 32'(fieldOut), 32'(vecIn[2 + 16 * (k / 2) + 5 * (k % 2) +: 4]));
    end
  endtask

  task automatic testOutside();
    logic [3:0] held;
    randVec();
    idxIn = 3'b101;
    settle(); #1;
    held = fieldOut;
    for (int b = 0; b < 64; b++) begin
      if (b < 39 || b > 42) begin
        vecIn[b] = ~vecIn[b];
        #1;
        check("R3 outside bits", 32'(fieldOut), 32'(held));
      end
    end
  endtask

  task automatic testSameCycle();
    randVec();
    idxIn = 3'b011;
    settle(); #1;
    vecIn[24:21] = ~vecIn[24:21];
    #1;
    check("R4 vector change", 32'(fieldOut), 32'(refField(vecIn, 1, 1)));
    idxIn = 3'b100;
    #1;
    check("R4 index change", 32'(fieldOut), 32'(refField(vecIn, 2, 0)));
  endtask

  task automatic testCorners();
    vecIn = 64'h0123_4567_89AB_CDEF;
    idxIn = 3'b000;
    settle(); #1;
    check("R6 base field", 32'(fieldOut), 32'(vecIn[5:2]));
    idxIn = 3'b111;
    #1;
    check("R7 top field", 32'(fieldOut), 32'(vecIn[58:55]));
    vecIn = 64'h0780_0000_0000_003C;
    idxIn = 3'b000;
    #1;
    check("R6 ones at base", 32'(fieldOut), 32'hF);
    idxIn = 3'b111;
    #1;
    check("R7 ones at top", 32'(fieldOut), 32'hF);
  endtask

  task automatic testSingle();
    for (int p = 0; p < 4; p++) begin
      sVec = 8'($urandom);
      for (int i = 0; i < 2; i++) begin
        sIdx = 1'(i);
        settle(); #1;
        check("R8 pass through", 32'(sOut), 32'(sVec[4:2]));
      end
    end
  endtask

  initial begin
    testReset();
    testSweep();
    testLinear();
    testOutside();
    testSameCycle();
    testCorners();
    testSingle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule